// File: doc/BRIEF.md
# Split-Enable Double-Buffered Converter Code Loader

This block is the digital front end of a 10-bit converter. It assembles the converter code from an 8-bit host bus under two active-low load enables. The high enable owns the top two code bits and the low enable owns the bottom eight. While an enable is held low, its bit group follows the bus on every clock. When the enable goes high again, the group keeps the last bus value that was sampled while it was low.

The block has two modes. In split mode a host writes the two top bits first and then the low byte, which takes two bus operations. In atomic mode a separate strobe first places the top two bits in a holding register. One pulse on the high enable then moves the held bits and the full bus byte into the code register together, so the output changes only once.

A one-cycle update flag marks every cycle in which the code register has just taken a new value. All inputs are sampled on the rising clock edge, and the enables are assumed to be synchronous to the clock already.

Top module: `dac_split_loader`

## Requirements
- R1: While `rst_n` is low, `code_q` reads 0 and `code_upd` reads 0. The holding register is also cleared to 0.
- R2: In split mode (`atomic_mode`=0), each clock edge with `lsb_en_n`=0 loads `bus_d[7:0]` into `code_q[7:0]`. The new value is visible after that edge.
- R3: In split mode, each clock edge with `msb_en_n`=0 loads `bus_d[1:0]` into `code_q[9:8]`. While an enable is high, its bit group holds the last value it loaded.
- R4: When both enables are high, changes on the bus or the strobe leave `code_q` unchanged.
- R5: In atomic mode, an edge with `pre_stb`=1 captures `bus_d[1:0]` into the holding register. An edge with `msb_en_n`=0 then loads `{held bits, bus_d[7:0]}` into all of `code_q` at once.
- R6: `lsb_en_n` has no effect in atomic mode. `pre_stb` has no effect in split mode.
- R7: In split mode, when both enables are low on the same edge, `code_q` becomes `{bus_d[1:0], bus_d[7:0]}`.
- R8: `code_upd` is 1 in exactly those cycles where `code_q` differs from its value one cycle earlier.
- R9: In atomic mode, if the strobe and the high enable are active on the same edge, the transfer uses the held bits from before that edge. The strobe still updates the holding register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_d | input | 8 | Host data bus |
| msb_en_n | input | 1 | Active-low enable for code bits 9:8 (full word in atomic mode) |
| lsb_en_n | input | 1 | Active-low enable for code bits 7:0 (split mode only) |
| pre_stb | input | 1 | Holding-register capture strobe (atomic mode) |
| atomic_mode | input | 1 | 0 = split two-step load, 1 = atomic load |
| code_q | output | 10 | Converter code register |
| code_upd | output | 1 | High for one cycle when code_q changes |

## Verification
The bench drives the low group alone and the high group alone, with distinct byte patterns. This shows that each enable writes only its own bits and takes the top bits from bus bits 1:0. Both enables low together and both high with a busy bus separate simultaneous loading from true holding. In atomic mode, the tests cover a strobe followed by a transfer, a strobe in the same cycle as the transfer, and a strobe issued in split mode. These show whether the held bits come from the right capture. A reload of an identical value checks that the update flag follows value changes and not enable activity.

// File: rtl/dacl_pkg.sv
package dacl_pkg;
  localparam int DACL_BUS_W = 8;
  localparam int DACL_MSB_W = 2;

  typedef enum logic {
    MODE_SPLIT  = 1'b0,
    MODE_ATOMIC = 1'b1
  } dacl_mode_e;
endpackage

// File: rtl/dacl_preload.sv
module dacl_preload #(
  parameter int MSB_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_ld,
  input  logic [MSB_W-1:0] pre_din,
  output logic [MSB_W-1:0] pre_q
);
  logic [MSB_W-1:0] pre_d;

  always_comb begin
    pre_d = pre_q;
    if (pre_ld) pre_d = pre_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (pre_ld) begin
      pre_q <= pre_d;
    end
  end

  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_ld |=> $stable(pre_q)); // R6
  AST_PRE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_ld |=> (pre_q == $past(pre_din))); // R5
endmodule

// File: rtl/dacl_code_reg.sv
module dacl_code_reg
  import dacl_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int MSB_W = 2,
  localparam int CODE_W = BUS_W + MSB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dacl_mode_e        mode,
  input  logic              msb_ld,
  input  logic              lsb_ld,
  input  logic [BUS_W-1:0]  bus,
  input  logic [MSB_W-1:0]  bus_top,
  input  logic [MSB_W-1:0]  held_top,
  output logic [CODE_W-1:0] code_q,
  output logic              upd_q
);
  logic [CODE_W-1:0] code_d;
  logic              code_en;
  logic              upd_d;

  always_comb begin
    code_d = code_q;
    if (mode == MODE_ATOMIC) begin
      if (msb_ld) code_d = {held_top, bus};
    end else begin
      if (msb_ld) code_d[CODE_W-1:BUS_W] = bus_top;
      if (lsb_ld) code_d[BUS_W-1:0]      = bus;
    end
    code_en = (code_d != code_q);
    upd_d   = code_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (code_en) begin
      code_q <= code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= 1'b0;
    end else begin
      upd_q <= upd_d;
    end
  end

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!msb_ld && !lsb_ld) |=> $stable(code_q)); // R4
  AST_LSB_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SPLIT && lsb_ld) |=> (code_q[BUS_W-1:0] == $past(bus))); // R2
  AST_MSB_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SPLIT && !msb_ld) |=> $stable(code_q[CODE_W-1:BUS_W])); // R3
  AST_ATOMIC_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ATOMIC && msb_ld) |=> (code_q == {$past(held_top), $past(bus)})); // R5
  AST_UPD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (upd_q == (code_q != $past(code_q)))); // R8
endmodule

// File: rtl/dac_split_loader.sv
module dac_split_loader
  import dacl_pkg::*;
#(
  parameter int BUS_W = DACL_BUS_W,
  parameter int MSB_W = DACL_MSB_W,
  localparam int CODE_W = BUS_W + MSB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  bus_d,
  input  logic              msb_en_n,
  input  logic              lsb_en_n,
  input  logic              pre_stb,
  input  logic              atomic_mode,
  output logic [CODE_W-1:0] code_q,
  output logic              code_upd
);
  dacl_mode_e       mode;
  logic             msb_ld;
  logic             lsb_ld;
  logic             pre_ld;
  logic [MSB_W-1:0] bus_top;
  logic [MSB_W-1:0] held_top;

  assign mode   = dacl_mode_e'(atomic_mode);
  assign msb_ld = !msb_en_n;
  assign lsb_ld = !lsb_en_n;
  assign pre_ld = pre_stb && (mode == MODE_ATOMIC);

  generate
    if (MSB_W <= BUS_W) begin : g_top_slice
      assign bus_top = bus_d[MSB_W-1:0];
    end else begin : g_top_pad
      assign bus_top = {{(MSB_W-BUS_W){1'b0}}, bus_d};
    end
  endgenerate

  dacl_preload #(.MSB_W(MSB_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .pre_ld  (pre_ld),
    .pre_din (bus_top),
    .pre_q   (held_top)
  );

  dacl_code_reg #(.BUS_W(BUS_W), .MSB_W(MSB_W)) u_code (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .msb_ld   (msb_ld),
    .lsb_ld   (lsb_ld),
    .bus      (bus_d),
    .bus_top  (bus_top),
    .held_top (held_top),
    .code_q   (code_q),
    .upd_q    (code_upd)
  );

  AST_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SPLIT && msb_ld && lsb_ld) |=> (code_q == {$past(bus_top), $past(bus_d)})); // R7
  AST_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_ld && msb_ld) |=> (code_q[CODE_W-1:BUS_W] == $past(held_top))); // R9
endmodule

// File: tb/dac_split_loader_test.sv
module dac_split_loader_test;
  logic       clk;
  logic       rst_n;
  logic [7:0] bus_d;
  logic       msb_en_n;
  logic       lsb_en_n;
  logic       pre_stb;
  logic       atomic_mode;
  logic [9:0] code_q;
  logic       code_upd;

  int checks;
  int failures;

  dac_split_loader uut (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .msb_en_n(msb_en_n),
    .lsb_en_n(lsb_en_n), .pre_stb(pre_stb), .atomic_mode(atomic_mode),
    .code_q(code_q), .code_upd(code_upd)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [9:0] exp_code, input logic exp_upd);
    checks++;
    if (code_q !== exp_code || code_upd !== exp_upd) begin
      failures++;
      $display("FAIL %s: code=%h upd=%b expected code=%h upd=%b",
               req, code_q, code_upd, exp_code, exp_upd);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; bus_d = 8'hFF; msb_en_n = 1'b1; lsb_en_n = 1'b1;
    pre_stb = 1'b0; atomic_mode = 1'b0;
    step(); step();
    chk("R1 reset", 10'h000, 1'b0);
    rst_n = 1'b1;
    step();
    chk("R1 after release", 10'h000, 1'b0);
  endtask

  task automatic t_lsb_track();
    lsb_en_n = 1'b0; bus_d = 8'hA5; step();
    chk("R2 low byte load", 10'h0A5, 1'b1);
    bus_d = 8'h3C; step();
    chk("R2 low byte tracks", 10'h03C, 1'b1);
    lsb_en_n = 1'b1; bus_d = 8'hFF; step();
    chk("R3 low byte holds after rise", 10'h03C, 1'b0);
  endtask

  task automatic t_msb_two_step();
    msb_en_n = 1'b0; bus_d = 8'hF2; step();
    chk("R3 top bits from bus[1:0]", 10'h23C, 1'b1);
    msb_en_n = 1'b1; lsb_en_n = 1'b0; bus_d = 8'h81; step();
    chk("R2 second step low byte", 10'h281, 1'b1);
    lsb_en_n = 1'b1; bus_d = 8'h00; step();
    chk("R3 word complete and held", 10'h281, 1'b0);
  endtask

  task automatic t_idle();
    pre_stb = 1'b1;
    for (int i = 0; i < 4; i++) begin
      bus_d = 8'h11 * i[7:0];
      step();
      chk("R4 idle bus ignored", 10'h281, 1'b0);
    end
    pre_stb = 1'b0;
  endtask

  task automatic t_both_low();
    msb_en_n = 1'b0; lsb_en_n = 1'b0; bus_d = 8'h57; step();
    chk("R7 both enables low", 10'h357, 1'b1);
    msb_en_n = 1'b1; lsb_en_n = 1'b1; step();
    chk("R8 no change no pulse", 10'h357, 1'b0);
  endtask

  task automatic t_atomic();
    atomic_mode = 1'b1; pre_stb = 1'b1; bus_d = 8'h01; step();
    chk("R4 strobe leaves code", 10'h357, 1'b0);
    pre_stb = 1'b0; msb_en_n = 1'b0; bus_d = 8'hC3; step();
    chk("R5 atomic full word", 10'h1C3, 1'b1);
    msb_en_n = 1'b1; bus_d = 8'h5A; step();
    chk("R5 atomic word held", 10'h1C3, 1'b0);
  endtask

  task automatic t_atomic_lsb_ignored();
    lsb_en_n = 1'b0; bus_d = 8'h00; step();
    chk("R6 low enable ignored in atomic", 10'h1C3, 1'b0);
    lsb_en_n = 1'b1;
  endtask

  task automatic t_strobe_split_ignored();
    atomic_mode = 1'b0; pre_stb = 1'b1; bus_d = 8'h03; step();
    pre_stb = 1'b0; atomic_mode = 1'b1; msb_en_n = 1'b0; bus_d = 8'h11; step();
    chk("R6 strobe ignored in split", 10'h111, 1'b1);
    msb_en_n = 1'b1;
  endtask

  task automatic t_same_edge();
    pre_stb = 1'b1; msb_en_n = 1'b0; bus_d = 8'h02; step();
    chk("R9 transfer uses old held bits", 10'h102, 1'b1);
    pre_stb = 1'b0; bus_d = 8'h44; step();
    chk("R9 strobe still captured", 10'h244, 1'b1);
    msb_en_n = 1'b1;
  endtask

  task automatic t_same_value();
    atomic_mode = 1'b0; lsb_en_n = 1'b0; bus_d = 8'h44; step();
    chk("R8 reload same value no pulse", 10'h244, 1'b0);
    lsb_en_n = 1'b1;
  endtask

  initial begin
    checks = 0;
    failures = 0;
    t_reset();
    t_lsb_track();
    t_msb_two_step();
    t_idle();
    t_both_low();
    t_atomic();
    t_atomic_lsb_ignored();
    t_strobe_split_ignored();
    t_same_edge();
    t_same_value();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #50000;
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule